// File: doc/BRIEF.md
# Serial Transmitter with Early Holding-Register-Empty Flag

This block is the transmit half of an asynchronous serial port. A software-visible holding register takes one byte per write strobe. A shift engine sends each byte as a frame of ten bits: one low start bit, eight data bits least significant first, and one high stop bit. One bit lasts from one baud tick to the next, and the line rests high between frames.

The holding-empty flag (`hold_empty`) goes high when the transmitter is switched on. After that it goes high at the moment the start bit of the current frame has left the line. That is also the moment the holding register's byte moves into the shifter. Software therefore has the whole data and stop phase, nine bit periods, to supply the next byte. When it does, the next frame follows the stop bit with no idle gap. The interrupt line is the flag gated by an interrupt-enable input.

The shift engine is a state machine with five states. OFF is the transmitter switched off, with the line high. IDLE is the line high with nothing to send. START drives the start bit. DATA shifts the eight data bits. STOP drives the stop bit. Its transitions are these:
- Enable moves OFF to IDLE.
- A tick with a byte waiting moves IDLE to START.
- Take: a tick in START moves to DATA and transfers the byte.
- The tick after the eighth data bit moves DATA to STOP.
- A tick moves STOP to START when another byte waits (chain), or to IDLE otherwise.
- Clearing the enable moves any state to OFF (abort).

Top module: `uart_tx_early`

## Requirements
- R1: While `tx_en` is low, the block behaves as follows:
  - `txd` is 1, `hold_empty` is 0 and `irq` is 0.
  - Write strobes are ignored: a byte written while the block is off is never sent after it is switched on.
- R2: In the clock after `tx_en` is first seen high, `hold_empty` becomes 1.
- R3: Each character goes out as a ten-bit frame, and each bit lasts exactly one baud-tick interval:
  - a start bit at 0;
  - the eight data bits, bit 0 first;
  - a stop bit at 1.
- R4: A write with the transmitter on stores `wr_data` and clears `hold_empty` on the next clock. A write while `hold_empty` is 0 replaces the stored byte without any error, so only the latest byte is sent.
- R5: `hold_empty` rises exactly one bit period after the start bit begins, at the tick that ends the start bit. The held byte moves to the shifter at that tick.
- R6: If a byte is waiting when the stop bit ends, the next start bit begins at once. Frame starts are then exactly ten bit periods apart.
- R7: From the idle line, a newly written byte's start bit begins at the first baud tick after the write.
- R8: `irq` equals `hold_empty` AND `irq_en`, with no added delay.
- R9: When `tx_en` drops, even in the middle of a frame, `txd` is 1 and `hold_empty` is 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| irq_en | input | 1 | Interrupt enable |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W (8) | Byte to transmit |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench counts the clocks from the fall of the start bit to the rise of `hold_empty`. A design that frees the holding register at the end of the frame fails this count by about nine bit periods. A design that frees it at the load fails by one.

A burst of bytes written as soon as the flag rises must produce frames exactly ten bit periods apart. A stray idle bit between stop and start, or a byte dropped in the chain, shows up as a gap or a missing frame.

Three further cases are covered:
- A second write before the frame leaves must send only the latest byte. A design that queues or ignores the overwrite sends the wrong data.
- A byte written while the block is off must never appear on the line.
- Turning the block off mid-frame must release the line high at once.

// File: rtl/uart_tx_early_pkg.sv
package uart_tx_early_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              empty_flag
);

    logic              en_q;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;

    // Flag priority: off clears, first enabled cycle sets,
    // a write clears (even when it lands on a take), a take sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
            data_q <= '0;
        end else begin
            en_q <= tx_en;
            if (!tx_en) begin
                flag_q <= 1'b0;
            end else if (!en_q) begin
                flag_q <= 1'b1;
            end else if (wr_en) begin
                flag_q <= 1'b0;
                data_q <= wr_data;
            end else if (take) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign hold_data  = data_q;
    assign hold_full  = en_q && !flag_q;
    assign empty_flag = flag_q;

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_early_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              txd,
    output tx_state_t         state
);

    localparam int                CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W - 1);

    tx_state_t         state_q;
    tx_state_t         state_nx;
    logic [DATA_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        if (!tx_en) begin
            state_nx = ST_OFF;                       // abort
        end else begin
            unique case (state_q)
                ST_OFF:   state_nx = ST_IDLE;       // enable
                ST_IDLE:  if (baud_tick && hold_full) state_nx = ST_START;
                ST_START: if (baud_tick) state_nx = ST_DATA;   // take
                ST_DATA:  if (baud_tick && cnt_q == LAST_BIT) state_nx = ST_STOP;
                ST_STOP:  if (baud_tick) state_nx = hold_full ? ST_START : ST_IDLE;
                default:  state_nx = ST_OFF;
            endcase
        end
    end

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            shift_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            if (take) begin
                shift_q <= hold_data;
                cnt_q   <= '0;
            end else if (state_q == ST_DATA && baud_tick) begin
                shift_q <= shift_q >> 1;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        take = 1'b0;
        txd  = 1'b1;
        unique case (state_q)
            ST_START: begin
                txd  = 1'b0;
                take = baud_tick && tx_en;
            end
            ST_DATA: txd = shift_q[0];
            default: txd = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/uart_tx_early.sv
module uart_tx_early
    import uart_tx_early_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              irq_en,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              irq
);

    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    tx_state_t         st;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_full  (hold_full),
        .empty_flag (hold_empty)
    );

    uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .baud_tick (baud_tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .take      (take),
        .txd       (txd),
        .state     (st)
    );

    assign irq = hold_empty && irq_en;

endmodule

// File: rtl/uart_tx_early_chk.sv
module uart_tx_early_chk
    import uart_tx_early_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tx_en,
    input logic      irq_en,
    input logic      baud_tick,
    input logic      wr_en,
    input logic      txd,
    input logic      hold_empty,
    input logic      irq,
    input tx_state_t st
);

    p_off_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && !hold_empty && !irq));

    p_enable_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !$past(tx_en)) |=> hold_empty);

    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START) |-> !txd);

    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_en && $past(tx_en)) |=> !hold_empty);

    p_early_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_START && baud_tick && tx_en && !wr_en) |=> hold_empty);

    p_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && baud_tick && tx_en && !hold_empty) |=> (st == ST_START));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (hold_empty && irq_en));

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && st == ST_DATA ##1 !tx_en) |=> (st == ST_OFF));

endmodule

bind uart_tx_early uart_tx_early_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .irq_en     (irq_en),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .txd        (txd),
    .hold_empty (hold_empty),
    .irq        (irq),
    .st         (st)
);

// File: tb/uart_tx_early_bench.sv
module uart_tx_early_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_en = 1'b0;
    logic          irq_en = 1'b0;
    logic          baud_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          txd;
    logic          hold_empty;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int frames = 0;
    int gap_exact = 0;
    int last_start = -1000;
    bit mute = 0;
    bit mon_busy = 0;
    bit done = 0;
    logic prev_txd = 1'b1;
    logic [DW-1:0] exp_q[$];

    uart_tx_early #(.DATA_W(DW)) u_uart_tx_early (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // baud tick generator: one cycle high every DIV cycles
    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % DIV;
            baud_tick = (tc == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_raw(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver: waits for the empty flag, writes, queues the expected byte
    task automatic send(input logic [DW-1:0] d);
        while (!hold_empty) @(negedge clk);
        exp_q.push_back(d);
        write_raw(d);
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0 || mon_busy || !hold_empty) @(negedge clk);
        repeat (2 * DIV) @(negedge clk);
    endtask

    // monitor: rebuilds frames from the line and compares with the queue
    initial begin
        logic [DW-1:0] got;
        logic [DW-1:0] e;
        logic st_ok, sp_ok;
        forever begin
            @(negedge clk);
            if (rst_n && prev_txd && !txd) begin
                mon_busy = 1;
                if (cyc - last_start == 10 * DIV) gap_exact++;
                last_start = cyc;
                repeat (DIV/2) @(negedge clk);
                st_ok = !txd;
                for (int i = 0; i < DW; i++) begin
                    repeat (DIV) @(negedge clk);
                    got[i] = txd;
                end
                repeat (DIV) @(negedge clk);
                sp_ok = txd;
                frames++;
                if (!mute) begin
                    chk(st_ok, "R3 start bit", st_ok, 1);
                    chk(sp_ok, "R3 stop bit", sp_ok, 1);
                    if (exp_q.size() == 0) begin
                        chk(0, "R3 unexpected frame", got, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(got == e, "R3 frame data LSB first", got, e);
                    end
                end
                prev_txd = 1'b1;
                mon_busy = 0;
            end else begin
                prev_txd = txd;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        int g0;
        int f0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: off state after reset
        chk(txd == 1 && hold_empty == 0 && irq == 0, "R1 off state", {txd, hold_empty, irq}, 3'b100);

        // R1: write while off is ignored
        write_raw(8'h3C);
        repeat (2) @(negedge clk);

        // R2: enabling sets the flag
        tx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(hold_empty == 1, "R2 enable sets flag", hold_empty, 1);
        f0 = frames;
        repeat (15 * DIV) @(negedge clk);
        chk(frames == f0, "R1 write while off not sent", frames, f0);

        // R8: interrupt gating
        irq_en = 1'b0;
        #1;
        chk(irq == 0, "R8 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk(irq == 1, "R8 irq follows flag", irq, 1);

        // R4, R7, R5: single frame from idle line
        cnt = 0;
        send(8'h5A);
        chk(hold_empty == 0, "R4 write clears flag", hold_empty, 0);
        chk(irq == 0, "R8 irq drops with flag", irq, 0);
        while (txd) begin @(negedge clk); cnt++; end
        chk(cnt >= 0 && cnt <= DIV, "R7 start at next tick", cnt, DIV);
        cnt = 0;
        while (!hold_empty) begin @(negedge clk); cnt++; end
        chk(cnt == DIV, "R5 flag after start bit", cnt, DIV);
        wait_drain();

        // R3: several data patterns
        send(8'h00);
        wait_drain();
        send(8'hFF);
        wait_drain();
        send(8'h01);
        wait_drain();
        send(8'h80);
        wait_drain();

        // R6: back-to-back burst
        g0 = gap_exact;
        send(8'hA3);
        send(8'h3A);
        send(8'hC5);
        send(8'h96);
        wait_drain();
        chk(gap_exact - g0 == 3, "R6 frames chained without idle", gap_exact - g0, 3);

        // R4: overwrite while full sends only the latest byte
        exp_q.push_back(8'h22);
        write_raw(8'h11);
        chk(hold_empty == 0, "R4 first write clears flag", hold_empty, 0);
        write_raw(8'h22);
        f0 = frames;
        wait_drain();
        chk(frames == f0 + 1, "R4 overwrite yields one frame", frames - f0, 1);

        // R9: abort mid-frame
        mute = 1;
        write_raw(8'hC3);
        while (txd) @(negedge clk);
        repeat (3 * DIV) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk(txd == 1 && hold_empty == 0, "R9 abort releases line", {txd, hold_empty}, 2'b10);
        repeat (12 * DIV) @(negedge clk);
        chk(txd == 1, "R1 line high while off", txd, 1);
        mute = 0;

        // re-enable and send once more
        tx_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(hold_empty == 1, "R2 re-enable sets flag", hold_empty, 1);
        send(8'hE7);
        wait_drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule